// File: doc/BRIEF.md
# Sine-Cosine Encoder Position Interpolator

This block turns one analog quadrature encoder into a fine-grained position word. Two paths feed it. The first is the pair of squared-up sine and cosine comparator signals, which drive a times-4 quadrature counter. The second is a pair of signed sine and cosine ADC samples. A shared programmable offset is removed from both samples, and an iterative CORDIC arctangent then locates the encoder within the current line.

The fine phase and the coarse line count are merged into a single 24-bit word. Its low 12 bits are the phase, so one line spans 4096 LSBs and one quadrature count spans 1024 LSBs. The two paths see the quarter-line edges at slightly different moments, so the merge corrects the line number at those edges and the word never jumps by a full line.

Samples arrive with a one-cycle `sampleValid` strobe. The block raises `busy` while a conversion runs and pulses `posValid` when the new word is ready.

Top module: `sineInterp`

## Requirements
- R1: Each legal quadrature transition changes the internal count by exactly one. The forward order of `{quadA,quadB}` is 00, 10, 11, 01, 00, and with `dirRev`=0 that order increments the count. Four counts make one line, and the line number is count bits [13:2].
- R2: With `dirRev`=1, the forward order decrements the count, and the sine sample is negated before the arctangent.
- R3: A transition in which both quadrature inputs change together leaves the count unchanged. It also sets `quadErr`, which stays high until reset. Inputs pass through two synchronizer flops, so the count or the error changes on the third rising edge after the input changes.
- R4: `bias`, a 24-bit two's complement value, is subtracted from both 24-bit two's complement samples before the angle is computed.
- R5: The 12-bit phase is within ±2 LSB of round(atan2(sin−bias, cos−bias)·4096/2π) mod 4096, in all four quadrants.
- R6: `posOut`[23:12] holds the (corrected) line number and `posOut`[11:0] holds the phase.
- R7: If count bits [1:0] are 3 and phase bits [11:10] are 0, the line number is raised by one. If count bits [1:0] are 0 and phase bits [11:10] are 3, the line number is lowered by one.
- R8: The line number wraps modulo 4096, so the position wraps modulo 2^24 and never saturates.
- R9: A sample is accepted on a rising edge where `sampleValid` is high and `busy` is low. `busy` is high from that edge until the 17th edge after it. On that 17th edge `busy` falls and `posValid` rises for exactly one cycle. `posOut` changes only on that edge.
- R10: `sampleValid` is ignored while `busy` is high. Such a pulse produces no extra `posValid` and does not change the result.
- R11: A synchronous reset clears the count, the error flag and `posOut`, and drives `busy` and `posValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| quadA | input | 1 | Squared sine comparator output (asynchronous) |
| quadB | input | 1 | Squared cosine comparator output (asynchronous) |
| dirRev | input | 1 | Reverse the counting and phase sense |
| bias | input | 24 | Offset removed from both samples, two's complement |
| sampleValid | input | 1 | Strobe qualifying sinIn and cosIn |
| sinIn | input | 24 | Sine ADC sample, two's complement |
| cosIn | input | 24 | Cosine ADC sample, two's complement |
| busy | output | 1 | Conversion in progress |
| posValid | output | 1 | One-cycle pulse: posOut updated |
| posOut | output | 24 | Position, LSB = 1/4096 line |
| quadErr | output | 1 | Sticky illegal-transition flag |

## Verification
A wrong quadrature count shows up in `posOut`[23:12] on the next conversion. A wrong phase register, such as a bad pre-rotation or a wrong arctangent step, shows up in the low bits of that same word. The bench therefore places its samples at chosen quadrant positions against known counts, including the two boundary cases where the line is corrected. A control-counter fault changes the busy window or the moment `posValid` rises. Both are compared on every clock, so such a fault is seen within one conversion, about 18 cycles. A stuck or non-sticky error flag is seen three cycles after a double transition.

// File: rtl/sineInterpPkg.sv
package sineInterpPkg;
  // Strobes from the sequencer to the arithmetic path
  typedef struct packed {
    logic load;    // capture offset-corrected samples and pre-rotate
    logic step;    // one CORDIC micro-rotation
    logic finish;  // merge phase with line count into the output word
  } ctrlStrobes_t;
endpackage

// File: rtl/quadCounter.sv
module quadCounter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             quadA,
  input  logic             quadB,
  input  logic             dirRev,
  output logic [CNT_W-1:0] count,
  output logic             quadErr
);
  logic [1:0] syncOne, syncTwo, prevAb;
  logic [1:0] idxCur, idxPrev, delta;
  logic       isFwd, isBwd, illegal, stepUp, stepDn;
  logic [CNT_W-1:0] cntR;
  logic       errR;

  // Gray position index: n[1] = B, n[0] = A ^ B
  assign idxCur  = {syncTwo[0], syncTwo[1] ^ syncTwo[0]};
  assign idxPrev = {prevAb[0],  prevAb[1]  ^ prevAb[0]};
  assign delta   = idxCur - idxPrev;
  assign isFwd   = (delta == 2'd1);
  assign isBwd   = (delta == 2'd3);
  assign illegal = (delta == 2'd2);
  assign stepUp  = dirRev ? isBwd : isFwd;
  assign stepDn  = dirRev ? isFwd : isBwd;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncOne <= '0;
      syncTwo <= '0;
      prevAb  <= '0;
      cntR    <= '0;
      errR    <= 1'b0;
    end else begin
      syncOne <= {quadA, quadB};
      syncTwo <= syncOne;
      prevAb  <= syncTwo;
      if (illegal)     errR <= 1'b1;
      else if (stepUp) cntR <= cntR + 1'b1;
      else if (stepDn) cntR <= cntR - 1'b1;
    end
  end

  assign count   = cntR;
  assign quadErr = errR;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    quadErr |=> quadErr); // R3
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    illegal |=> $stable(count)); // R3
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(count) |-> ((count - $past(count)) == CNT_W'(1)) ||
                        ((count - $past(count)) == {CNT_W{1'b1}})); // R1
endmodule

// File: rtl/interpCtrl.sv
module interpCtrl import sineInterpPkg::*; #(
  parameter int ITER  = 16,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleValid,
  output ctrlStrobes_t     strb,
  output logic [IDX_W-1:0] iterIdx,
  output logic             busy,
  output logic             posValid
);
  logic             busyR, validR;
  logic [IDX_W-1:0] iterCnt;

  always_comb begin
    strb.load   = sampleValid && !busyR;
    strb.step   = busyR && (iterCnt != IDX_W'(ITER));
    strb.finish = busyR && (iterCnt == IDX_W'(ITER));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyR   <= 1'b0;
      validR  <= 1'b0;
      iterCnt <= '0;
    end else begin
      validR <= strb.finish;
      if (strb.load) begin
        busyR   <= 1'b1;
        iterCnt <= '0;
      end else if (strb.step) begin
        iterCnt <= iterCnt + 1'b1;
      end else if (strb.finish) begin
        busyR <= 1'b0;
      end
    end
  end

  assign iterIdx  = iterCnt;
  assign busy     = busyR;
  assign posValid = validR;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    posValid |=> !posValid); // R9
  AST_BUSY_ENDS_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> posValid); // R9
  AST_BUSY_NOT_ABANDONED: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || posValid)); // R10
endmodule

// File: rtl/interpDatapath.sv
module interpDatapath import sineInterpPkg::*; #(
  parameter int SAMPLE_W = 24,
  parameter int PHASE_W  = 12,
  parameter int POS_W    = 24,
  parameter int IDX_W    = 5,
  parameter int CNT_W    = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strb,
  input  logic [IDX_W-1:0]    iterIdx,
  input  logic                dirRev,
  input  logic [SAMPLE_W-1:0] bias,
  input  logic [SAMPLE_W-1:0] sinIn,
  input  logic [SAMPLE_W-1:0] cosIn,
  input  logic [CNT_W-1:0]    count,
  output logic [POS_W-1:0]    posOut
);
  localparam int XW     = SAMPLE_W + 3;
  localparam int ZW     = 32;
  localparam int LINE_W = POS_W - PHASE_W;

  // atan(2^-i) in units of 2^-32 turn
  function automatic logic [ZW-1:0] atanStep(input logic [IDX_W-1:0] idx);
    case (int'(idx))
      0:  return 32'd536870912;
      1:  return 32'd316933406;
      2:  return 32'd167458907;
      3:  return 32'd85004756;
      4:  return 32'd42667331;
      5:  return 32'd21354465;
      6:  return 32'd10679838;
      7:  return 32'd5340245;
      8:  return 32'd2670163;
      9:  return 32'd1335087;
      10: return 32'd667544;
      11: return 32'd333772;
      12: return 32'd166886;
      13: return 32'd83443;
      14: return 32'd41722;
      15: return 32'd20861;
      default: return '0;
    endcase
  endfunction

  logic signed [XW-1:0] sinD, cosD, sinE, xR, yR, xSh, ySh;
  logic [ZW-1:0]        zR, zRound;
  logic [PHASE_W-1:0]   phase;
  logic [LINE_W-1:0]    lineBase, lineAdj;
  logic [POS_W-1:0]     posR;

  assign sinD = {{3{sinIn[SAMPLE_W-1]}}, sinIn} - {{3{bias[SAMPLE_W-1]}}, bias};
  assign cosD = {{3{cosIn[SAMPLE_W-1]}}, cosIn} - {{3{bias[SAMPLE_W-1]}}, bias};
  assign sinE = dirRev ? -sinD : sinD;
  assign xSh  = xR >>> iterIdx;
  assign ySh  = yR >>> iterIdx;

  assign zRound   = zR + (ZW'(1) << (ZW - PHASE_W - 1));
  assign phase    = zRound[ZW-1 -: PHASE_W];
  assign lineBase = count[CNT_W-1:2];

  always_comb begin
    lineAdj = lineBase;
    if (count[1:0] == 2'd3 && phase[PHASE_W-1 -: 2] == 2'd0)
      lineAdj = lineBase + 1'b1;
    else if (count[1:0] == 2'd0 && phase[PHASE_W-1 -: 2] == 2'd3)
      lineAdj = lineBase - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xR   <= '0;
      yR   <= '0;
      zR   <= '0;
      posR <= '0;
    end else if (strb.load) begin
      if (cosD[XW-1]) begin
        xR <= -cosD;
        yR <= -sinE;
        zR <= ZW'(1) << (ZW - 1);
      end else begin
        xR <= cosD;
        yR <= sinE;
        zR <= '0;
      end
    end else if (strb.step) begin
      if (!yR[XW-1]) begin
        xR <= xR + ySh;
        yR <= yR - xSh;
        zR <= zR + atanStep(iterIdx);
      end else begin
        xR <= xR - ySh;
        yR <= yR + xSh;
        zR <= zR - atanStep(iterIdx);
      end
    end else if (strb.finish) begin
      posR <= {lineAdj, phase};
    end
  end

  assign posOut = posR;

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !strb.finish |=> $stable(posOut)); // R9
  AST_LOAD_NOT_MIDRUN: assert property (@(posedge clk) disable iff (rst)
    strb.step |-> !strb.load); // R10
endmodule

// File: rtl/sineInterp.sv
module sineInterp import sineInterpPkg::*; #(
  parameter int SAMPLE_W = 24,
  parameter int PHASE_W  = 12,
  parameter int POS_W    = 24,
  parameter int ITER     = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                quadA,
  input  logic                quadB,
  input  logic                dirRev,
  input  logic [SAMPLE_W-1:0] bias,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sinIn,
  input  logic [SAMPLE_W-1:0] cosIn,
  output logic                busy,
  output logic                posValid,
  output logic [POS_W-1:0]    posOut,
  output logic                quadErr
);
  localparam int IDX_W = $clog2(ITER + 1);
  localparam int CNT_W = POS_W - PHASE_W + 2;

  ctrlStrobes_t     strb;
  logic [IDX_W-1:0] iterIdx;
  logic [CNT_W-1:0] count;

  quadCounter #(.CNT_W(CNT_W)) i_quadCounter (
    .clk(clk), .rst(rst), .quadA(quadA), .quadB(quadB), .dirRev(dirRev),
    .count(count), .quadErr(quadErr)
  );

  interpCtrl #(.ITER(ITER), .IDX_W(IDX_W)) i_interpCtrl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .strb(strb),
    .iterIdx(iterIdx), .busy(busy), .posValid(posValid)
  );

  interpDatapath #(
    .SAMPLE_W(SAMPLE_W), .PHASE_W(PHASE_W), .POS_W(POS_W),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) i_interpDatapath (
    .clk(clk), .rst(rst), .strb(strb), .iterIdx(iterIdx), .dirRev(dirRev),
    .bias(bias), .sinIn(sinIn), .cosIn(cosIn), .count(count), .posOut(posOut)
  );
endmodule

// File: tb/test_sineInterp.sv
`timescale 1ns/1ps
module test_sineInterp;
  localparam int AMP = 1 << 20;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic quadA = 1'b0, quadB = 1'b0, dirRev = 1'b0, sampleValid = 1'b0;
  logic [23:0] bias = '0, sinIn = '0, cosIn = '0;
  logic busy, posValid, quadErr;
  logic [23:0] posOut;

  sineInterp i_sineInterp (
    .clk(clk), .rst(rst), .quadA(quadA), .quadB(quadB), .dirRev(dirRev),
    .bias(bias), .sampleValid(sampleValid), .sinIn(sinIn), .cosIn(cosIn),
    .busy(busy), .posValid(posValid), .posOut(posOut), .quadErr(quadErr)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  int checks = 0, errors = 0;
  bit monOn = 1'b0;
  int busyFrom = -10, busyTo = -10, validAt = -10, errAt = -1;
  int expPos = 0;
  int modelCnt = 0, phys = 0;
  string curReq = "R11";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkPos(string req);
    int diff;
    checks++;
    diff = (int'(posOut) - expPos) & 32'h00FFFFFF;
    if (!(diff <= 2 || diff >= (1 << 24) - 2)) begin
      errors++;
      $display("FAIL %s posOut act=%h exp=%h", req, posOut, expPos);
    end
  endtask

  // Reference model, compared on every clock
  always @(negedge clk) begin
    if (monOn) begin
      check("R9", "busy", int'(busy), int'(cyc >= busyFrom && cyc <= busyTo));
      check("R9", "posValid", int'(posValid), int'(cyc == validAt));
      check("R3", "quadErr", int'(quadErr), int'(errAt >= 0 && cyc >= errAt));
      if (posValid && cyc == validAt) checkPos(curReq);
    end
  end

  always @(posedge clk) begin
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic toDrive();
    @(negedge clk);
    #1;
  endtask

  // R6: line in [23:12], phase in [11:0]; R7 correction; R8 wrap
  function automatic int refPos(int sEff, int cVal, int cnt);
    real ang;
    int ph, line, q;
    ang = $atan2(real'(sEff), real'(cVal));
    ph = $rtoi($floor(ang / TWO_PI * 4096.0 + 0.5));
    ph = ((ph % 4096) + 4096) % 4096;
    line = cnt >> 2;
    q = cnt & 3;
    if (q == 3 && (ph >> 10) == 0) line = line + 1;
    else if (q == 0 && (ph >> 10) == 3) line = line - 1;
    return ((line & 4095) << 12) | ph;
  endfunction

  task automatic driveQuad();
    int n;
    n = phys & 3;
    quadA = n[1] ^ n[0];
    quadB = n[1];
  endtask

  task automatic stepQuad(bit up);
    toDrive();
    phys = up ? phys + 1 : phys - 1;
    driveQuad();
    modelCnt = (modelCnt + ((up ^ dirRev) ? 1 : -1)) & 16383;
    repeat (4) toDrive();
  endtask

  task automatic illegalQuad();
    toDrive();
    phys = phys + 2;
    driveQuad();
    if (errAt < 0) errAt = cyc + 3;
    repeat (4) toDrive();
  endtask

  task automatic sendSample(real deg, int biasV, string req);
    int s, c;
    real r;
    toDrive();
    while (busy) toDrive();
    r = deg / 360.0 * TWO_PI;
    s = $rtoi($floor(real'(AMP) * $sin(r) + 0.5));
    c = $rtoi($floor(real'(AMP) * $cos(r) + 0.5));
    bias = biasV[23:0];
    sinIn = 24'(biasV + s);
    cosIn = 24'(biasV + c);
    sampleValid = 1'b1;
    busyFrom = cyc + 1;
    busyTo = cyc + 17;
    validAt = cyc + 18;
    expPos = refPos(dirRev ? -s : s, c, modelCnt);
    curReq = req;
    toDrive();
    sampleValid = 1'b0;
  endtask

  task automatic waitDone();
    while (cyc <= validAt) toDrive();
  endtask

  task automatic doReset();
    monOn = 1'b0;
    toDrive();
    rst = 1'b1;
    quadA = 1'b0;
    quadB = 1'b0;
    phys = 0;
    modelCnt = 0;
    errAt = -1;
    busyFrom = -10;
    busyTo = -10;
    validAt = -10;
    repeat (4) toDrive();
    rst = 1'b0;
    monOn = 1'b1;
    toDrive();
    check("R11", "posOut after reset", int'(posOut), 0);
    check("R11", "busy after reset", int'(busy), 0);
    check("R11", "posValid after reset", int'(posValid), 0);
    check("R11", "quadErr after reset", int'(quadErr), 0);
  endtask

  initial begin
    doReset();

    // R5: phase across quadrants at count 0
    sendSample(30.0, 0, "R5 R6");
    sendSample(120.0, 0, "R5");
    sendSample(200.0, 0, "R5");
    sendSample(250.0, 0, "R5");
    waitDone();

    // R1: five forward steps, line 1 quadrant 1
    repeat (5) stepQuad(1'b1);
    sendSample(100.0, 0, "R1 R6");
    waitDone();

    // R7: count 7 (q=3) with phase in quadrant 0 -> line + 1
    repeat (2) stepQuad(1'b1);
    sendSample(4.0, 0, "R7");
    waitDone();

    // R7: count 8 (q=0) with phase in quadrant 3 -> line - 1
    stepQuad(1'b1);
    sendSample(356.0, 0, "R7");
    waitDone();

    // R4: positive and negative offsets
    sendSample(45.0, 32'sh400000, "R4");
    sendSample(135.0, -32'sh200000, "R4");
    waitDone();

    // R10: a strobe during a conversion is ignored
    sendSample(60.0, 0, "R10");
    repeat (3) toDrive();
    sinIn = 24'h300000;
    cosIn = 24'hD00000;
    sampleValid = 1'b1;
    toDrive();
    sampleValid = 1'b0;
    waitDone();
    repeat (5) toDrive();
    checkPos("R10");

    // R9: back-to-back conversions with no idle cycle
    sendSample(10.0, 0, "R9");
    sendSample(80.0, 0, "R9");
    waitDone();

    // R3: double transition sets the flag and leaves the count at 8
    illegalQuad();
    sendSample(45.0, 0, "R3");
    waitDone();
    stepQuad(1'b1);
    sendSample(100.0, 0, "R3");
    waitDone();

    // R8: count below zero wraps to the top line
    doReset();
    repeat (2) stepQuad(1'b0);
    sendSample(200.0, 0, "R8");
    waitDone();

    // R2: reversed sense decrements and negates the sine
    dirRev = 1'b1;
    stepQuad(1'b1);
    sendSample(250.0, 0, "R2");
    waitDone();
    repeat (4) stepQuad(1'b1);
    sendSample(250.0, 0, "R2");
    waitDone();
    repeat (3) toDrive();

    monOn = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule